// File: doc/BRIEF.md
# Configurable Multiplexer Logic Cell

This block models one fine-grained cell of a programmable logic fabric. Its core is a four-way selector over four data lines. The two selector controls come from two small gates. The low control is the AND of two inputs and the high control is the OR of two other inputs. A static two-bit mode field sets what follows the selector. The cell can be purely combinational, can register the result in an edge-triggered flop with an asynchronous clear, or can hold it in a level-sensitive latch, with or without a clear.

Storage modes take over some of the cell's inputs. Both register modes without a dedicated clear pin drop one input of the AND gate, which leaves a seven-input function. The clearable latch mode also loses the AND gate altogether, and with it two of the data lines, which leaves a four-input function. The shared clock/gate pin is an edge clock in flop mode and a level enable in the latch modes.

Top module: `mlc_cell`

## Requirements
- R1: The selector output is `din[2*s_hi + s_lo]`; that is, din[0] for (0,0), din[1] for s_lo=1, din[2] for s_hi=1 and din[3] for both set.
- R2: In pass mode `s_hi = or_a | or_b` and `s_lo = and_a & and_b`.
- R3: Mode 2'b00 (pass) drives `cell_out` straight from the selector, with no dependence on `clk_g` or `clr`.
- R4: In modes 2'b01 (flop) and 2'b10 (plain latch), `and_b` is ignored and `s_lo = and_a`.
- R5: In mode 2'b11 (clearable latch), `s_lo` is held at 0, so `and_a`, `and_b`, `din[1]` and `din[3]` have no effect and `cell_out` follows `or_a | or_b ? din[2] : din[0]`.
- R6: In mode 2'b01, `cell_out` takes the selector value on each rising edge of `clk_g` and holds it at all other times.
- R7: In modes 2'b10 and 2'b11, `cell_out` follows the selector while `clk_g` is high and holds its last value while `clk_g` is low.
- R8: In modes 2'b01 and 2'b11, a high `clr` forces `cell_out` to 0 at once, whatever the state of `clk_g`.
- R9: In mode 2'b10, `clr` has no effect on `cell_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_g | input | 1 | Rising-edge clock in flop mode, active-high gate in latch modes |
| clr | input | 1 | Asynchronous active-high clear for the clearable modes |
| mode | input | 2 | Static mode field: 00 pass, 01 flop, 10 latch, 11 clearable latch |
| din | input | 4 | Selector data lines, indexed by {s_hi, s_lo} |
| and_a | input | 1 | First input of the low-select AND gate |
| and_b | input | 1 | Second input of the low-select AND gate |
| or_a | input | 1 | First input of the high-select OR gate |
| or_b | input | 1 | Second input of the high-select OR gate |
| cell_out | output | 1 | Cell result |

## Verification
Pass mode and a transparent latch have no register in the path, so the bench samples `cell_out` a short delay after each input change in the same cycle. In flop mode the result is due at the rising edge that captures it. The bench samples two time units after that edge, then changes the inputs while the clock is still high and samples again to confirm the value holds until the next edge. A clear is checked right after it rises with the clock low, which shows that it acts without waiting for an edge. Latch hold is checked after the gate falls, across several input changes.

// File: rtl/mlc_pkg.sv
package mlc_pkg;

    localparam int NUM_DATA = 4;
    localparam int SEL_W    = $clog2(NUM_DATA);

    typedef enum logic [1:0] {
        MODE_PASS   = 2'b00,
        MODE_FLOP   = 2'b01,
        MODE_LAT    = 2'b10,
        MODE_LATCLR = 2'b11
    } cell_mode_e;

    typedef struct packed {
        logic flop;
    } store_state_t;

endpackage

// File: rtl/mlc_select_gen.sv
module mlc_select_gen
    import mlc_pkg::*;
(
    input  cell_mode_e         mode,
    input  logic               and_a,
    input  logic               and_b,
    input  logic               or_a,
    input  logic               or_b,
    output logic [SEL_W-1:0]   sel
);
    logic and_b_eff;
    logic s_lo;
    logic s_hi;

    always_comb begin
        // Register modes borrow and_b; clearable latch borrows the whole AND gate.
        and_b_eff = (mode == MODE_PASS) ? and_b : 1'b1;
        s_lo      = (mode == MODE_LATCLR) ? 1'b0 : (and_a & and_b_eff);
        s_hi      = or_a | or_b;
        sel       = {s_hi, s_lo};
    end
endmodule

// File: rtl/mlc_mux.sv
module mlc_mux
    import mlc_pkg::*;
#(
    parameter int N  = NUM_DATA,
    localparam int SW = $clog2(N)
) (
    input  logic [N-1:0]  din,
    input  logic [SW-1:0] sel,
    output logic          y
);
    logic [N-1:0] hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_leg
            assign hit[i] = din[i] & (sel == SW'(i));
        end
    endgenerate

    assign y = |hit;
endmodule

// File: rtl/mlc_store.sv
module mlc_store
    import mlc_pkg::*;
(
    input  logic       clk_g,
    input  logic       clr,
    input  cell_mode_e mode,
    input  logic       y,
    output logic       flop_q_o,
    output logic       lat_q_o
);
    store_state_t st_d;
    store_state_t st_q;
    logic         flop_clr;
    logic         lat_clr;
    logic         lat_q;

    assign flop_clr = clr & (mode == MODE_FLOP);
    assign lat_clr  = clr & (mode == MODE_LATCLR);

    always_comb begin
        st_d      = st_q;
        st_d.flop = y;
    end

    always_ff @(posedge clk_g or posedge flop_clr) begin
        if (flop_clr) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_latch begin
        if (lat_clr) begin
            lat_q = 1'b0;
        end else if (clk_g) begin
            lat_q = y;
        end
    end

    assign flop_q_o = st_q.flop;
    assign lat_q_o  = lat_q;
endmodule

// File: rtl/mlc_cell.sv
module mlc_cell
    import mlc_pkg::*;
(
    input  logic                clk_g,
    input  logic                clr,
    input  logic [1:0]          mode,
    input  logic [NUM_DATA-1:0] din,
    input  logic                and_a,
    input  logic                and_b,
    input  logic                or_a,
    input  logic                or_b,
    output logic                cell_out
);
    cell_mode_e       mode_e;
    logic [SEL_W-1:0] sel;
    logic             y;
    logic             flop_q;
    logic             lat_q;

    assign mode_e = cell_mode_e'(mode);

    mlc_select_gen u_sel (
        .mode  (mode_e),
        .and_a (and_a),
        .and_b (and_b),
        .or_a  (or_a),
        .or_b  (or_b),
        .sel   (sel)
    );

    mlc_mux #(.N(NUM_DATA)) u_mux (
        .din (din),
        .sel (sel),
        .y   (y)
    );

    mlc_store u_store (
        .clk_g    (clk_g),
        .clr      (clr),
        .mode     (mode_e),
        .y        (y),
        .flop_q_o (flop_q),
        .lat_q_o  (lat_q)
    );

    always_comb begin
        case (mode_e)
            MODE_PASS: cell_out = y;
            MODE_FLOP: cell_out = flop_q;
            default:   cell_out = lat_q;
        endcase
    end
endmodule

// File: rtl/mlc_cell_chk.sv
module mlc_cell_chk (
    input logic       clk_g,
    input logic       clr,
    input logic [1:0] mode,
    input logic [3:0] din,
    input logic       and_a,
    input logic       and_b,
    input logic       or_a,
    input logic       or_b,
    input logic       cell_out
);
    logic s_hi_m;
    logic s_lo_m;
    logic exp_y;

    always_comb begin
        s_hi_m = or_a | or_b;
        case (mode)
            2'b00:   s_lo_m = and_a & and_b;
            2'b11:   s_lo_m = 1'b0;
            default: s_lo_m = and_a;
        endcase
        exp_y = din[{s_hi_m, s_lo_m}];
    end

    // R3
    pass_comb_chk: assert property (@(negedge clk_g) disable iff (clr)
        (mode == 2'b00) |-> (cell_out == exp_y));

    // R6
    flop_cap_chk: assert property (@(posedge clk_g) disable iff (clr)
        (mode == 2'b01 && $past(mode) == 2'b01 && !$past(clr)) |-> (cell_out == $past(exp_y)));

    // R7
    lat_follow_chk: assert property (@(negedge clk_g) disable iff (clr)
        (mode[1]) |-> (cell_out == exp_y));

    // R8
    clr_zero_chk: assert property (@(posedge clk_g)
        (clr && (mode == 2'b01 || mode == 2'b11)) |-> (cell_out == 1'b0));
endmodule

bind mlc_cell mlc_cell_chk u_chk (
    .clk_g    (clk_g),
    .clr      (clr),
    .mode     (mode),
    .din      (din),
    .and_a    (and_a),
    .and_b    (and_b),
    .or_a     (or_a),
    .or_b     (or_b),
    .cell_out (cell_out)
);

// File: tb/sim_mlc_cell.sv
module sim_mlc_cell;
    localparam int PERIOD = 10;
    localparam int HALF   = PERIOD / 2;

    logic       clk_g;
    logic       clr;
    logic [1:0] mode;
    logic [3:0] din;
    logic       and_a, and_b, or_a, or_b;
    logic       cell_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic held;

    mlc_cell u0 (
        .clk_g(clk_g), .clr(clr), .mode(mode), .din(din),
        .and_a(and_a), .and_b(and_b), .or_a(or_a), .or_b(or_b),
        .cell_out(cell_out)
    );

    function automatic logic model(logic [1:0] m, logic [3:0] d,
                                   logic aa, logic ab, logic oa, logic ob);
        logic hi, lo;
        hi = oa | ob;
        if (m == 2'b00)      lo = aa & ab;
        else if (m == 2'b11) lo = 1'b0;
        else                 lo = aa;
        return d[{hi, lo}];
    endfunction

    function automatic logic cur_model();
        return model(mode, din, and_a, and_b, or_a, or_b);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: cell_out=%b expected=%b (mode=%b din=%b a=%b%b o=%b%b)",
                     req, act, exp, mode, din, and_a, and_b, or_a, or_b);
        end
    endtask

    task automatic rnd_inputs();
        din   = 4'($urandom);
        and_a = 1'($urandom);
        and_b = 1'($urandom);
        or_a  = 1'($urandom);
        or_b  = 1'($urandom);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd1357));
        clk_g = 0; clr = 1; mode = 2'b01;
        din = 4'b1111; and_a = 1; and_b = 1; or_a = 1; or_b = 1;
        #3 chk("R8 reset", cell_out, 1'b0);
        #2 clr = 0;

        // R1 directed: one-hot data, each select combination
        mode = 2'b00;
        for (int s = 0; s < 4; s++) begin
            din = 4'b0001 << s;
            or_a = s[1]; or_b = 0; and_a = s[0]; and_b = s[0];
            #2 chk("R1", cell_out, 1'b1);
            din = ~(4'b0001 << s);
            #2 chk("R1", cell_out, 1'b0);
        end
        // R2 gate polarity: and needs both, or needs either
        din = 4'b0010; and_a = 1; and_b = 0; or_a = 0; or_b = 0;
        #2 chk("R2", cell_out, 1'b0);
        din = 4'b0100; or_b = 1;
        #2 chk("R2", cell_out, 1'b1);

        // R2/R3 random pass vectors with clock and clear activity
        for (int i = 0; i < 150; i++) begin
            rnd_inputs();
            clr = 1'($urandom);
            #2 chk("R3", cell_out, cur_model());
            clk_g = 1;
            #2 chk("R2", cell_out, cur_model());
            clk_g = 0;
            #1;
        end
        clr = 0;

        // R6 flop capture and hold
        mode = 2'b01;
        #HALF clk_g = 1; #HALF clk_g = 0;
        for (int i = 0; i < 60; i++) begin
            logic e;
            rnd_inputs();
            #2 e = cur_model();
            clk_g = 1;
            #2 chk("R6 capture", cell_out, e);
            rnd_inputs();
            #2 chk("R6 hold", cell_out, e);
            clk_g = 0;
            #2 rnd_inputs();
            #2 chk("R6 hold low", cell_out, e);
        end
        // R4 flop mode: and_b ignored
        din = 4'b0010; and_a = 1; and_b = 0; or_a = 0; or_b = 0;
        #2 clk_g = 1;
        #2 chk("R4 flop", cell_out, 1'b1);
        #2 clk_g = 0;
        // R8 async clear in flop mode while clock low
        #2 clr = 1;
        #1 chk("R8 flop async", cell_out, 1'b0);
        #2 clk_g = 1;
        #2 chk("R8 flop edge", cell_out, 1'b0);
        #2 clk_g = 0;
        #1 clr = 0;
        #2 clk_g = 1;
        #2 chk("R6 after clear", cell_out, 1'b1);
        #2 clk_g = 0;

        // R7 plain latch: follow while high
        mode = 2'b10;
        #2 clk_g = 1;
        for (int i = 0; i < 40; i++) begin
            rnd_inputs();
            #2 chk("R7 follow", cell_out, cur_model());
        end
        // R4 latch mode: and_b ignored
        din = 4'b0010; and_a = 1; and_b = 0; or_a = 0; or_b = 0;
        #2 chk("R4 latch", cell_out, 1'b1);
        #2 clk_g = 0;
        held = 1'b1;
        for (int i = 0; i < 5; i++) begin
            rnd_inputs();
            #2 chk("R7 hold", cell_out, held);
        end
        // R9 clear ignored in plain latch mode
        clr = 1;
        #2 chk("R9 low", cell_out, held);
        clk_g = 1;
        din = 4'b0001; and_a = 0; and_b = 0; or_a = 0; or_b = 0;
        #2 chk("R9 high", cell_out, 1'b1);
        clk_g = 0;
        #1 clr = 0;

        // R5 clearable latch: 4-input function
        mode = 2'b11;
        #2 clk_g = 1;
        for (int i = 0; i < 40; i++) begin
            rnd_inputs();
            #2 chk("R5", cell_out, din[{or_a | or_b, 1'b0}]);
        end
        din = 4'b1010; and_a = 1; and_b = 1; or_a = 0; or_b = 0;
        #2 chk("R5 s_lo forced", cell_out, 1'b0);
        or_a = 1;
        #2 chk("R5 s_lo forced", cell_out, 1'b0);
        din = 4'b0101;
        #2 chk("R5 d2", cell_out, 1'b1);
        // R8 clear overrides open gate
        clr = 1;
        #1 chk("R8 latch", cell_out, 1'b0);
        #1 clr = 0;
        #1 chk("R7 resume", cell_out, 1'b1);
        #2 clk_g = 0;
        din = 4'b0000;
        #2 chk("R7 hold clr mode", cell_out, 1'b1);
        clr = 1;
        #1 chk("R8 latch low", cell_out, 1'b0);
        #1 clr = 0;
        #2 chk("R7 held zero", cell_out, 1'b0);

        #PERIOD;
        report();
    end
endmodule